// File: doc/BRIEF.md
# Decoder Error Statistics Accumulator

This block measures how well a forward error correction decoder performs. It receives three 128-bit streams in lockstep. The first carries the reference data that was sent. The second carries the hard decisions taken from the channel before decoding. The third carries the decoder output. Each stream is split into codeblocks. For each path the block counts the bits that differ from the reference, and it counts a codeblock as errored whenever at least one of its counted bits differs. It also counts the blocks it has processed and sums the iteration count the decoder reports for each block, so that software can compute an average.

Software programs the run through a small write port. The values it sets are the number of blocks, the information length k, the full codeword length n, and four 32-bit words that mask the final beat of a block. A start command then clears every counter and begins the run. When the programmed number of blocks has been consumed the block raises `idle` again, and software reads the six counters. Each counter stops at its maximum value instead of wrapping.

Top module: `dec_err_stats`

## Requirements
- R1: After reset `idle` is 1, every counter output is 0 and the three ready outputs are 0.
- R2: A beat is consumed only while a run is active and all three valid inputs are 1. In that case all three readies are 1 together. Otherwise all three readies are 0, and this includes every cycle while idle.
- R3: For each consumed beat, the raw bit counter grows by popcount((reference XOR raw) AND mask) and the corrected bit counter grows by popcount((reference XOR decoded) AND mask). The mask is all ones on every beat except the last beat of a block.
- R4: On the last beat of a block the mask is the 128-bit value held in config addresses 3 to 6. Address 3+i sets bits 32i+31 down to 32i.
- R5: A block spans ceil(L/128) beats. L is the value at address 1 (k), or the value at address 2 (n) when bit 1 of the start write is 1. An L of 0 counts as one beat.
- R6: The raw and corrected block counters each grow by one at the end of a block in which their own path had at least one masked differing bit, on any beat of that block.
- R7: `blk_total` grows by one per finished block. `iter_total` adds the `dec_iter` value present on the last beat of each block.
- R8: A write of 1 in bit 0 at address 7 while idle clears all six counters. It starts a run of the block count held at address 0, and `idle` returns to 1 after that many blocks. A count of 0 leaves the block idle with the counters cleared.
- R9: Each counter saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| src_tvalid | input | 1 | Reference beat valid |
| src_tdata | input | 128 | Reference beat |
| src_tready | output | 1 | Reference beat accepted |
| raw_tvalid | input | 1 | Pre-decode hard-decision beat valid |
| raw_tdata | input | 128 | Pre-decode hard-decision beat |
| raw_tready | output | 1 | Pre-decode beat accepted |
| dec_tvalid | input | 1 | Decoder output beat valid |
| dec_tdata | input | 128 | Decoder output beat |
| dec_iter | input | ITER_W | Decoder iterations for the current block |
| dec_tready | output | 1 | Decoder beat accepted |
| idle | output | 1 | No run in progress |
| raw_bit_errs | output | CNT_W | Raw bit error count |
| raw_blk_errs | output | CNT_W | Raw block error count |
| cor_bit_errs | output | CNT_W | Corrected bit error count |
| cor_blk_errs | output | CNT_W | Corrected block error count |
| blk_total | output | CNT_W | Blocks processed |
| iter_total | output | CNT_W | Sum of decoder iterations |

## Verification
The assertions assume that software does not start a run with more blocks than the counters can hold. With that limit, the processed-block count at the end of a run equals the programmed count. They also assume that the start command is written only while idle. The bench keeps within these limits by using block counts of at most a few dozen. It waits for `idle` before it issues each new configuration. It holds the data and `dec_iter` of each beat steady until the three streams accept that beat together, and it randomizes only the valid inputs while a beat is pending.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
  localparam int BEAT_W   = 128;
  localparam int LANE_W   = 32;
  localparam int LANES    = BEAT_W / LANE_W;
  localparam int POP_W    = $clog2(BEAT_W) + 1;
  localparam int BEAT_LG  = $clog2(BEAT_W);

  // number of set bits in one beat
  function automatic logic [POP_W-1:0] ones_in(input logic [BEAT_W-1:0] v);
    logic [POP_W-1:0] c;
    c = '0;
    for (int i = 0; i < BEAT_W; i++) c = c + POP_W'(v[i]);
    return c;
  endfunction

  // beats occupied by a block of len bits; an empty block still takes one beat
  function automatic int unsigned beats_for(input int unsigned len);
    int unsigned b;
    b = (len + BEAT_W - 1) >> BEAT_LG;
    return (b == 0) ? 1 : b;
  endfunction
endpackage

// File: rtl/dstat_cmp.sv
module dstat_cmp
  import dstat_pkg::*;
(
  input  logic [BEAT_W-1:0] ref_d,
  input  logic [BEAT_W-1:0] rx_d,
  input  logic [BEAT_W-1:0] keep,
  output logic [POP_W-1:0]  nerr,
  output logic              any_err
);
  logic [BEAT_W-1:0] diff;

  always_comb begin
    diff    = (ref_d ^ rx_d) & keep;
    nerr    = ones_in(diff);
    any_err = |diff;
  end
endmodule

// File: rtl/dstat_sat_acc.sv
module dstat_sat_acc #(
  parameter int W  = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  q
);
  logic [W:0]   sum;
  logic [W-1:0] q_n;

  always_comb begin
    sum = {1'b0, q} + (W+1)'(inc);
    q_n = sum[W] ? '1 : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q_n;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> q >= $past(q)); // R9
endmodule

// File: rtl/dec_err_stats.sv
module dec_err_stats
  import dstat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 20,
  parameter int ITER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic                src_tvalid,
  input  logic [127:0]        src_tdata,
  output logic                src_tready,
  input  logic                raw_tvalid,
  input  logic [127:0]        raw_tdata,
  output logic                raw_tready,
  input  logic                dec_tvalid,
  input  logic [127:0]        dec_tdata,
  input  logic [ITER_W-1:0]   dec_iter,
  output logic                dec_tready,
  output logic                idle,
  output logic [CNT_W-1:0]    raw_bit_errs,
  output logic [CNT_W-1:0]    raw_blk_errs,
  output logic [CNT_W-1:0]    cor_bit_errs,
  output logic [CNT_W-1:0]    cor_blk_errs,
  output logic [CNT_W-1:0]    blk_total,
  output logic [CNT_W-1:0]    iter_total
);
  localparam int BC_W = LEN_W - BEAT_LG + 1;
  localparam logic [2:0] A_NBLK = 3'd0, A_KLEN = 3'd1, A_NLEN = 3'd2,
                         A_MASK0 = 3'd3, A_CTRL = 3'd7;

  logic [CNT_W-1:0]  nblk_q, blk_idx_q;
  logic [LEN_W-1:0]  klen_q, nlen_q, len_sel;
  logic [BEAT_W-1:0] mask_q, beat_mask;
  logic [BC_W-1:0]   beats_q, beat_idx_q;
  logic              busy_q, raw_hit_q, cor_hit_q;

  // named events for assertions and accumulators
  logic start_ev, fire, last_beat, blk_end;
  logic [POP_W-1:0] raw_nerr, cor_nerr;
  logic raw_any, cor_any;

  always_comb begin
    start_ev  = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0] && !busy_q;
    fire      = busy_q && src_tvalid && raw_tvalid && dec_tvalid;
    last_beat = (beat_idx_q == beats_q - BC_W'(1));
    blk_end   = fire && last_beat;
    beat_mask = last_beat ? mask_q : '1;
    len_sel   = cfg_wdata[1] ? nlen_q : klen_q;
  end

  assign src_tready = fire;
  assign raw_tready = fire;
  assign dec_tready = fire;
  assign idle       = !busy_q;

  dstat_cmp u_cmp_raw (.ref_d(src_tdata), .rx_d(raw_tdata), .keep(beat_mask),
                       .nerr(raw_nerr), .any_err(raw_any));
  dstat_cmp u_cmp_cor (.ref_d(src_tdata), .rx_d(dec_tdata), .keep(beat_mask),
                       .nerr(cor_nerr), .any_err(cor_any));

  // configuration registers, frozen during a run
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nblk_q <= '0;
      klen_q <= '0;
      nlen_q <= '0;
      mask_q <= '1;
    end else if (cfg_we && !busy_q) begin
      if (cfg_addr == A_NBLK) nblk_q <= cfg_wdata[CNT_W-1:0];
      if (cfg_addr == A_KLEN) klen_q <= cfg_wdata[LEN_W-1:0];
      if (cfg_addr == A_NLEN) nlen_q <= cfg_wdata[LEN_W-1:0];
      for (int i = 0; i < LANES; i++)
        if (cfg_addr == A_MASK0 + 3'(i)) mask_q[LANE_W*i +: LANE_W] <= cfg_wdata;
    end
  end

  // run sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      beats_q    <= BC_W'(1);
      beat_idx_q <= '0;
      blk_idx_q  <= '0;
      raw_hit_q  <= 1'b0;
      cor_hit_q  <= 1'b0;
    end else if (start_ev) begin
      busy_q     <= (nblk_q != '0);
      beats_q    <= BC_W'(beats_for(32'(len_sel)));
      beat_idx_q <= '0;
      blk_idx_q  <= '0;
      raw_hit_q  <= 1'b0;
      cor_hit_q  <= 1'b0;
    end else if (fire) begin
      if (last_beat) begin
        beat_idx_q <= '0;
        raw_hit_q  <= 1'b0;
        cor_hit_q  <= 1'b0;
        blk_idx_q  <= blk_idx_q + CNT_W'(1);
        if (blk_idx_q == nblk_q - CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        beat_idx_q <= beat_idx_q + BC_W'(1);
        raw_hit_q  <= raw_hit_q | raw_any;
        cor_hit_q  <= cor_hit_q | cor_any;
      end
    end
  end

  // saturating statistics counters
  dstat_sat_acc #(.W(CNT_W), .IW(POP_W)) u_raw_bits (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(fire), .inc(raw_nerr), .q(raw_bit_errs));
  dstat_sat_acc #(.W(CNT_W), .IW(POP_W)) u_cor_bits (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(fire), .inc(cor_nerr), .q(cor_bit_errs));
  dstat_sat_acc #(.W(CNT_W), .IW(1)) u_raw_blks (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(blk_end && (raw_hit_q || raw_any)), .inc(1'b1), .q(raw_blk_errs));
  dstat_sat_acc #(.W(CNT_W), .IW(1)) u_cor_blks (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(blk_end && (cor_hit_q || cor_any)), .inc(1'b1), .q(cor_blk_errs));
  dstat_sat_acc #(.W(CNT_W), .IW(1)) u_blocks (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(blk_end), .inc(1'b1), .q(blk_total));
  dstat_sat_acc #(.W(CNT_W), .IW(ITER_W)) u_iters (.clk(clk), .rst_n(rst_n),
    .clr(start_ev), .en(blk_end), .inc(dec_iter), .q(iter_total));

  AST_RAW_BLK_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    raw_blk_errs <= blk_total); // R6
  AST_COR_BLK_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    cor_blk_errs <= blk_total); // R6
  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> beat_idx_q < beats_q); // R5
  AST_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> blk_total == nblk_q); // R8
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_ev) |=> $stable(blk_total) && $stable(raw_bit_errs)); // R8
endmodule

// File: tb/dec_err_stats_bench.sv
`timescale 1ns/1ps
module dec_err_stats_bench;
  localparam int CW = 12;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic src_tvalid = 0, raw_tvalid = 0, dec_tvalid = 0;
  logic [127:0] src_tdata = '0, raw_tdata = '0, dec_tdata = '0;
  logic [7:0] dec_iter = '0;
  logic src_tready, raw_tready, dec_tready, idle;
  logic [CW-1:0] raw_bit_errs, raw_blk_errs, cor_bit_errs, cor_blk_errs, blk_total, iter_total;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dec_err_stats #(.CNT_W(CW), .LEN_W(20), .ITER_W(8)) u_dec_err_stats (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_tvalid(src_tvalid), .src_tdata(src_tdata), .src_tready(src_tready),
    .raw_tvalid(raw_tvalid), .raw_tdata(raw_tdata), .raw_tready(raw_tready),
    .dec_tvalid(dec_tvalid), .dec_tdata(dec_tdata), .dec_iter(dec_iter), .dec_tready(dec_tready),
    .idle(idle), .raw_bit_errs(raw_bit_errs), .raw_blk_errs(raw_blk_errs),
    .cor_bit_errs(cor_bit_errs), .cor_blk_errs(cor_blk_errs),
    .blk_total(blk_total), .iter_total(iter_total));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint count_set(input logic [127:0] v);
    longint c = 0;
    logic [127:0] t = v;
    while (t != '0) begin t = t & (t - 1); c++; end
    return c;
  endfunction

  function automatic logic [127:0] tail_mask(input int len);
    logic [127:0] m = '0;
    int r = len % 128;
    if (r == 0) return '1;
    for (int b = 0; b < r; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [127:0] err_pat(input int mode);
    logic [127:0] e = '0;
    if (mode == 2) return '1;
    if (mode == 1)
      for (int l = 0; l < 4; l++)
        if ($urandom % 3 == 0) e[32*l +: 32] = $urandom & $urandom & $urandom;
    return e;
  endfunction

  function automatic longint sat(input longint v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic cfg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input int nblk, input int k, input int n, input bit use_n,
                          input int mr, input int md, input string tag);
    int len = use_n ? n : k;
    int beats = (len + 127) / 128;
    logic [127:0] tm = tail_mask(len);
    longint e_rb = 0, e_rk = 0, e_cb = 0, e_ck = 0, e_it = 0;
    if (beats == 0) beats = 1;
    cfg_wr(0, 32'(nblk));
    cfg_wr(1, 32'(k));
    cfg_wr(2, 32'(n));
    for (int l = 0; l < 4; l++) cfg_wr(3 + l, tm[32*l +: 32]);
    cfg_wr(7, {30'd0, use_n, 1'b1});
    for (int b = 0; b < nblk; b++) begin
      bit rhit = 0, chit = 0;
      for (int t = 0; t < beats; t++) begin
        logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
        logic [127:0] er = err_pat(mr), ed = err_pat(md);
        logic [127:0] m = (t == beats - 1) ? tm : '1;
        logic [7:0] it = 8'($urandom % 40);
        bit sv, rv, dv;
        longint nr = count_set(er & m), nc = count_set(ed & m);
        e_rb += nr; e_cb += nc;
        if (nr != 0) rhit = 1;
        if (nc != 0) chit = 1;
        if (t == beats - 1) e_it += it;
        do begin
          @(negedge clk);
          src_tdata = s; raw_tdata = s ^ er; dec_tdata = s ^ ed; dec_iter = it;
          sv = ($urandom % 4) != 0; rv = ($urandom % 4) != 0; dv = ($urandom % 4) != 0;
          src_tvalid = sv; raw_tvalid = rv; dec_tvalid = dv;
          #0.5;
          // R2: readies together, only with all three valid
          chk(src_tready == (sv & rv & dv) && raw_tready == src_tready && dec_tready == src_tready,
              "R2 ready", longint'(src_tready), longint'(sv & rv & dv));
        end while (!(sv && rv && dv));
      end
      if (rhit) e_rk++;
      if (chit) e_ck++;
    end
    @(negedge clk);
    src_tvalid = 0; raw_tvalid = 0; dec_tvalid = 0;
    for (int w = 0; w < 50 && !idle; w++) @(negedge clk);
    $display("case %s", tag);
    chk(idle == 1'b1, "R8 idle after run", longint'(idle), 1);
    chk(raw_bit_errs == sat(e_rb), "R3/R4/R9 raw bits", raw_bit_errs, sat(e_rb));
    chk(cor_bit_errs == sat(e_cb), "R3/R4 corrected bits", cor_bit_errs, sat(e_cb));
    chk(raw_blk_errs == sat(e_rk), "R6 raw blocks", raw_blk_errs, sat(e_rk));
    chk(cor_blk_errs == sat(e_ck), "R6 corrected blocks", cor_blk_errs, sat(e_ck));
    chk(blk_total == sat(nblk), "R7/R5 block total", blk_total, nblk);
    chk(iter_total == sat(e_it), "R7 iteration sum", iter_total, sat(e_it));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(raw_bit_errs == 0 && cor_bit_errs == 0 && raw_blk_errs == 0 && cor_blk_errs == 0
        && blk_total == 0 && iter_total == 0, "R1 counters", raw_bit_errs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    src_tvalid = 1; raw_tvalid = 1; dec_tvalid = 1;
    #0.5;
    chk(src_tready == 0 && raw_tready == 0 && dec_tready == 0, "R1/R2 ready while idle",
        longint'(src_tready), 0);
    src_tvalid = 0; raw_tvalid = 0; dec_tvalid = 0;

    run_case(3, 128, 0, 0, 1, 1, "R3 full beat");
    run_case(4, 200, 0, 0, 1, 0, "R4 partial tail");
    run_case(5, 100, 0, 0, 2, 1, "R4 one partial beat");
    run_case(3, 100, 300, 1, 1, 1, "R5 parity length");
    run_case(2, 0, 0, 0, 1, 1, "R5 empty length");
    run_case(0, 64, 0, 0, 1, 1, "R8 zero blocks");
    run_case(1, 5120, 0, 0, 2, 0, "R9 saturation");
    for (int r = 0; r < 6; r++)
      run_case(1 + $urandom % 5, 1 + $urandom % 600, 1 + $urandom % 900, 1'($urandom % 2),
               $urandom % 3, $urandom % 2, "R3 random");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule